// File: doc/BRIEF.md
# Speculative Next-PC Selector with Misprediction Redirect

This block picks the next fetch address for a five-stage pipeline that uses branch prediction. In the fetch stage it takes the predicted-taken bit and the predicted target that the predictor tables return for the current fetch PC. It forwards the predicted target when the bit is set and the sequential address (fetch PC plus the instruction step) when it is clear. The same prediction pair is captured into a short shift chain. The chain carries it alongside the instruction until the instruction reaches the memory stage, where the branch decision and target are known.

In the memory stage the carried prediction is compared with the resolved outcome. A wrong direction, or a wrong target on an instruction that really is taken, raises `mispredict`. This flag overrides the fetch-stage choice with the correct address. It is also the signal the hazard logic uses to flush the younger instructions. The block also drives the two predictor-table write enables: one for the direction table and one for the target buffer. The table index and the write data come straight from the memory-stage PC and the resolved values, outside this block.

Top module: `nextpc_redirect`

## Requirements
- R1: With `mispredict` low, `next_pc` equals `pred_target_f` when `pred_taken_f` is 1, and `fetch_pc + 4` otherwise, in the same cycle (combinational).
- R2: A direction mismatch exists when `mem_taken` differs from the taken bit carried with the memory-stage instruction. It raises `mispredict` and `hist_we` in that cycle. `hist_we` is never high without it.
- R3: A target mismatch exists only when `mem_taken` is 1 and the carried target differs from `mem_target`. It raises `mispredict` and `tgt_we`. `tgt_we` is high exactly when this mismatch exists.
- R4: An instruction resolved not taken, whose carried taken bit is also 0, never raises `mispredict`, whatever its carried target.
- R5: With `mispredict` high, `next_pc` equals `mem_target` when `mem_taken` is 1, and `mem_pc + 4` otherwise.
- R6: A prediction presented at fetch in cycle t is the one compared in the memory stage in cycle t+3, which is three clock edges later.
- R7: Synchronous reset (`rst` high at an edge) clears every carried prediction to taken=0 and target=0.
- R8: An edge with `mispredict` high clears every carried prediction to taken=0 and target=0, so flushed slots can never flag a misprediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | PC of the instruction being fetched |
| pred_taken_f | input | 1 | Predicted-taken bit for the fetch PC |
| pred_target_f | input | PC_W | Predicted target for the fetch PC |
| mem_pc | input | PC_W | PC of the memory-stage instruction |
| mem_taken | input | 1 | Resolved taken bit of the memory-stage instruction (0 for non-branches) |
| mem_target | input | PC_W | Resolved target address of the memory-stage instruction |
| next_pc | output | PC_W | Address to load into the PC register |
| mispredict | output | 1 | Redirect and flush request |
| hist_we | output | 1 | Write enable for the direction table |
| tgt_we | output | 1 | Write enable for the target buffer |

## Verification
Every cycle, the checker confirms that `next_pc` follows the speculative choice when there is no redirect and the resolved address when there is one. It also confirms that the write enables appear only together with `mispredict`, that `tgt_we` needs a taken outcome, and that a cycle after a flush cannot mispredict unless the branch is actually taken. The alignment of a prediction with its instruction three stages later, the exact split between direction and target mismatches, and the clearing of in-flight predictions by reset and by a flush depend on what was fed in earlier cycles. Only the bench's sequenced scenarios show those.

// File: rtl/redirect_pkg.sv
package redirect_pkg;
  localparam int PC_W_DEF    = 32;
  localparam int PC_STEP_DEF = 4;
  localparam int CARRY_DEF   = 3;  // fetch -> decode -> execute -> memory
endpackage

// File: rtl/rdr_fetch_mux.sv
module rdr_fetch_mux #(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            pred_taken,
  input  logic [PC_W-1:0] pred_target,
  output logic [PC_W-1:0] spec_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_comb begin
    if (pred_taken) spec_pc = pred_target;
    else            spec_pc = fetch_pc + STEP;
  end
endmodule

// File: rtl/rdr_pred_pipe.sv
module rdr_pred_pipe #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            in_taken,
  input  logic [PC_W-1:0] in_target,
  output logic            out_taken,
  output logic [PC_W-1:0] out_target
);
  generate
    if (DEPTH == 0) begin : g_bypass
      assign out_taken  = in_taken;
      assign out_target = in_target;
    end else begin : g_chain
      logic [DEPTH-1:0]           tk_q;
      logic [DEPTH-1:0][PC_W-1:0] tg_q;

      always_ff @(posedge clk) begin
        if (rst || flush) begin
          tk_q <= '0;
          tg_q <= '0;
        end else begin
          for (int s = DEPTH - 1; s > 0; s--) begin
            tk_q[s] <= tk_q[s-1];
            tg_q[s] <= tg_q[s-1];
          end
          tk_q[0] <= in_taken;
          tg_q[0] <= in_target;
        end
      end

      assign out_taken  = tk_q[DEPTH-1];
      assign out_target = tg_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/rdr_resolve.sv
module rdr_resolve #(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            car_taken,
  input  logic [PC_W-1:0] car_target,
  input  logic [PC_W-1:0] mem_pc,
  input  logic            mem_taken,
  input  logic [PC_W-1:0] mem_target,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc,
  output logic            hist_we,
  output logic            tgt_we
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic dir_miss;
  logic tgt_miss;

  always_comb begin
    dir_miss    = mem_taken ^ car_taken;
    tgt_miss    = mem_taken & (car_target != mem_target);
    mispredict  = dir_miss | tgt_miss;
    redirect_pc = mem_taken ? mem_target : (mem_pc + STEP);
    hist_we     = dir_miss;
    tgt_we      = tgt_miss;
  end
endmodule

// File: rtl/nextpc_redirect.sv
module nextpc_redirect #(
  parameter int PC_W    = redirect_pkg::PC_W_DEF,
  parameter int PC_STEP = redirect_pkg::PC_STEP_DEF,
  parameter int CARRY   = redirect_pkg::CARRY_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            pred_taken_f,
  input  logic [PC_W-1:0] pred_target_f,
  input  logic [PC_W-1:0] mem_pc,
  input  logic            mem_taken,
  input  logic [PC_W-1:0] mem_target,
  output logic [PC_W-1:0] next_pc,
  output logic            mispredict,
  output logic            hist_we,
  output logic            tgt_we
);
  logic [PC_W-1:0] spec_pc;
  logic [PC_W-1:0] redirect_pc;
  logic            car_taken;
  logic [PC_W-1:0] car_target;

  rdr_fetch_mux #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_fetch_mux (
    .fetch_pc    (fetch_pc),
    .pred_taken  (pred_taken_f),
    .pred_target (pred_target_f),
    .spec_pc     (spec_pc)
  );

  rdr_pred_pipe #(.PC_W(PC_W), .DEPTH(CARRY)) u_pred_pipe (
    .clk        (clk),
    .rst        (rst),
    .flush      (mispredict),
    .in_taken   (pred_taken_f),
    .in_target  (pred_target_f),
    .out_taken  (car_taken),
    .out_target (car_target)
  );

  rdr_resolve #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_resolve (
    .car_taken   (car_taken),
    .car_target  (car_target),
    .mem_pc      (mem_pc),
    .mem_taken   (mem_taken),
    .mem_target  (mem_target),
    .mispredict  (mispredict),
    .redirect_pc (redirect_pc),
    .hist_we     (hist_we),
    .tgt_we      (tgt_we)
  );

  assign next_pc = mispredict ? redirect_pc : spec_pc;
endmodule

// File: rtl/nextpc_redirect_chk.sv
module nextpc_redirect_chk #(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_taken_f,
  input logic [PC_W-1:0] pred_target_f,
  input logic [PC_W-1:0] mem_pc,
  input logic            mem_taken,
  input logic [PC_W-1:0] mem_target,
  input logic [PC_W-1:0] next_pc,
  input logic            mispredict,
  input logic            hist_we,
  input logic            tgt_we
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  AST_SPEC_SELECT: assert property (@(posedge clk) disable iff (rst)
    !mispredict |-> next_pc == (pred_taken_f ? pred_target_f : fetch_pc + STEP)); // R1

  AST_WE_NEEDS_MISP: assert property (@(posedge clk) disable iff (rst)
    (hist_we || tgt_we) |-> mispredict); // R2

  AST_TGT_WE_TAKEN: assert property (@(posedge clk) disable iff (rst)
    tgt_we |-> mem_taken); // R3

  AST_NOTTAKEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!mem_taken && !hist_we) |-> !mispredict); // R4

  AST_REDIRECT_ADDR: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> next_pc == (mem_taken ? mem_target : mem_pc + STEP)); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $fell(rst) |-> (mem_taken || !mispredict)); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    mispredict |=> (mem_taken || !mispredict)); // R8
endmodule

bind nextpc_redirect nextpc_redirect_chk #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fetch_pc      (fetch_pc),
  .pred_taken_f  (pred_taken_f),
  .pred_target_f (pred_target_f),
  .mem_pc        (mem_pc),
  .mem_taken     (mem_taken),
  .mem_target    (mem_target),
  .next_pc       (next_pc),
  .mispredict    (mispredict),
  .hist_we       (hist_we),
  .tgt_we        (tgt_we)
);

// File: tb/test_nextpc_redirect.sv
`timescale 1ns/1ps
module test_nextpc_redirect;
  localparam int W = 32;

  typedef struct packed {
    logic         pt;    // predicted taken at fetch
    logic [W-1:0] ptgt;  // predicted target at fetch
    logic [W-1:0] fpc;   // fetch PC
    logic [W-1:0] mpc;   // memory-stage PC
    logic         mt;    // resolved taken
    logic [W-1:0] mtgt;  // resolved target
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0100, 32'h0000_0040, 32'h0000_0040, 1'b1, 32'h0000_0100}, // correct taken
    '{1'b0, 32'h0000_0000, 32'h0000_0080, 32'h0000_0080, 1'b0, 32'h0000_0000}, // correct not taken
    '{1'b0, 32'h0000_0000, 32'h0000_00C0, 32'h0000_00C0, 1'b1, 32'h0000_0200}, // direction miss, taken
    '{1'b1, 32'h0000_0300, 32'h0000_0100, 32'h0000_0100, 1'b0, 32'h0000_0300}, // direction miss, not taken
    '{1'b1, 32'h0000_0300, 32'h0000_0140, 32'h0000_0140, 1'b1, 32'h0000_0380}, // target miss only
    '{1'b0, 32'h0000_0700, 32'h0000_0180, 32'h0000_0180, 1'b0, 32'h0000_0123}, // stale target, not taken
    '{1'b1, 32'h0000_0600, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1'b1, 32'h0000_0600}  // fetch PC wrap
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] fetch_pc = '0;
  logic         pred_taken_f = 1'b0;
  logic [W-1:0] pred_target_f = '0;
  logic [W-1:0] mem_pc = '0;
  logic         mem_taken = 1'b0;
  logic [W-1:0] mem_target = '0;
  logic [W-1:0] next_pc;
  logic         mispredict, hist_we, tgt_we;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  nextpc_redirect i_nextpc_redirect (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_taken_f(pred_taken_f),
    .pred_target_f(pred_target_f), .mem_pc(mem_pc), .mem_taken(mem_taken),
    .mem_target(mem_target), .next_pc(next_pc), .mispredict(mispredict),
    .hist_we(hist_we), .tgt_we(tgt_we)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    pred_taken_f = 1'b0; pred_target_f = '0;
    mem_taken = 1'b0; mem_target = '0; mem_pc = '0;
  endtask

  initial begin
    // reset state
    repeat (2) @(negedge clk);
    rst = 1'b0;
    fetch_pc = 32'h0000_1000;
    @(negedge clk);
    #1;
    chk("R7", "mispredict after reset", W'(mispredict), '0);
    chk("R1", "next_pc after reset", next_pc, 32'h0000_1004);

    // vector table: predict at fetch, resolve three edges later
    for (int i = 0; i < NV; i++) begin
      logic dmis, tmis, mis;
      logic [W-1:0] exp_next;
      @(negedge clk);
      idle_inputs();
      fetch_pc = VECS[i].fpc;
      pred_taken_f = VECS[i].pt;
      pred_target_f = VECS[i].ptgt;
      #1;
      chk("R1", "speculative next_pc", next_pc,
          VECS[i].pt ? VECS[i].ptgt : VECS[i].fpc + 32'd4);
      @(negedge clk);
      pred_taken_f = 1'b0; pred_target_f = '0;
      @(negedge clk);
      @(negedge clk);
      mem_pc = VECS[i].mpc; mem_taken = VECS[i].mt; mem_target = VECS[i].mtgt;
      #1;
      dmis = VECS[i].mt != VECS[i].pt;
      tmis = VECS[i].mt && (VECS[i].ptgt != VECS[i].mtgt);
      mis = dmis | tmis;
      exp_next = mis ? (VECS[i].mt ? VECS[i].mtgt : VECS[i].mpc + 32'd4) : VECS[i].fpc + 32'd4;
      chk("R6 R2 R3 R4", "mispredict", W'(mispredict), W'(mis));
      chk("R2", "hist_we", W'(hist_we), W'(dmis));
      chk("R3", "tgt_we", W'(tgt_we), W'(tmis));
      chk("R5", "next_pc at resolve", next_pc, exp_next);
    end

    // flush clears an in-flight taken prediction
    @(negedge clk);
    idle_inputs();
    fetch_pc = 32'h0000_2000;
    pred_taken_f = 1'b1; pred_target_f = 32'h0000_0A00;
    @(negedge clk);
    pred_taken_f = 1'b0; pred_target_f = '0;
    mem_pc = 32'h0000_1F00; mem_taken = 1'b1; mem_target = 32'h0000_0B00;
    #1;
    chk("R2", "forced direction miss", W'(mispredict), W'(1));
    chk("R5", "redirect to resolved target", next_pc, 32'h0000_0B00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      idle_inputs();
      #1;
      chk("R8", "no mispredict after flush", W'(mispredict), '0);
    end

    // reset clears an in-flight taken prediction
    @(negedge clk);
    pred_taken_f = 1'b1; pred_target_f = 32'h0000_0900;
    @(negedge clk);
    pred_taken_f = 1'b0; pred_target_f = '0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      chk("R7", "no mispredict after reset", W'(mispredict), '0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule